// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block turns one interrupt request into the set of processors that should receive it. A request can describe its target in one of three ways: as plain fields on dedicated inputs, as the two words of an interprocessor command register, or as the address and data of a message-signalled write. The block pulls the destination byte, the destination mode, the shorthand, the delivery mode, the vector and the trigger and level bits out of the chosen source. It then compares the destination with the identity registers of every processor slot in a parameterised array.

Each slot provides its physical ID byte, its logical destination register word and its destination format register word, plus a present flag. In physical mode the destination is compared with the IDs. In logical mode each slot is matched by the model its format register selects: flat or cluster. A shorthand can replace the destination with the sender alone, with every slot, or with every slot except the sender. For lowest-priority delivery, the mask is cut down to one target.

The result is registered. It appears, with a one-cycle valid strobe and the decoded vector, delivery mode, trigger and level, on the clock edge that follows the request. The interrupt controllers that consume the mask do the injection and any priority arbitration.

Top module: `irq_dest_resolver`

## Requirements
- R1: While reset is asserted, and until the first request afterwards, `res_valid` is 0 and `res_mask` is all zeros.
- R2: A request sampled high at a rising edge makes `res_valid` 1 for exactly the following cycle. `res_mask` and the decoded outputs keep their last values while no request is made.
- R3: In physical mode (mode bit 0), destination 0xFF selects every slot. Any other destination selects each slot whose ID byte equals it, and selects no slot if none is equal.
- R4: In logical mode (mode bit 1), a slot whose format field (bits 31:28 of its format word) is 0xF matches when the destination AND its logical ID (bits 31:24 of its logical word) is nonzero.
- R5: In logical mode, a slot whose format field is 0x0 matches when the destination and its logical ID have equal upper nibbles and lower nibbles with at least one common set bit. A slot with any other format value never matches in logical mode.
- R6: Shorthand 0 uses the destination. Shorthand 1 selects only the slot at index `sender`. Shorthand 2 selects all slots. Shorthand 3 selects all slots except `sender`. A sender index of NCPU or more names no slot.
- R7: A slot whose `cpu_present` bit is 0 is never set in `res_mask`.
- R8: When the delivery mode is 3'b001 (lowest priority), `res_mask` holds only the lowest-indexed bit of the matched set, or is zero if the set is empty.
- R9: With `src_sel` = 0, the destination, mode, shorthand, delivery mode, vector, trigger and level come from the `d_*` inputs.
- R10: With `src_sel` = 1, the fields come from the command words. In `cmd_lo`: vector in bits 7:0, delivery mode in bits 10:8, destination mode in bit 11, level in bit 14, trigger in bit 15 and shorthand in bits 19:18. The destination is in `cmd_hi` bits 31:24.
- R11: With `src_sel` = 2 or 3, the fields come from a message write. The destination is address bits 19:12 and the destination mode is address bit 2. From the data word: vector bits 7:0, delivery mode bits 10:8, level bit 14 and trigger bit 15. The shorthand is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Resolve request |
| src_sel | input | 2 | Field source: 0 direct, 1 command words, 2/3 message write |
| sender | input | SW | Index of the requesting slot |
| d_dest | input | 8 | Direct destination |
| d_logical | input | 1 | Direct destination mode (1 = logical) |
| d_short | input | 2 | Direct shorthand |
| d_dmode | input | 3 | Direct delivery mode |
| d_vector | input | 8 | Direct vector |
| d_trig | input | 1 | Direct trigger |
| d_level | input | 1 | Direct level |
| cmd_lo | input | 32 | Command register low word |
| cmd_hi | input | 32 | Command register high word |
| msg_addr | input | 32 | Message write address |
| msg_data | input | 32 | Message write data |
| cpu_ids | input | 8*NCPU | Physical ID byte per slot |
| cpu_ldr | input | 32*NCPU | Logical destination word per slot |
| cpu_dfr | input | 32*NCPU | Destination format word per slot |
| cpu_present | input | NCPU | Slot populated flag |
| res_valid | output | 1 | Result strobe |
| res_mask | output | NCPU | Target slot mask |
| res_vector | output | 8 | Decoded vector |
| res_dmode | output | 3 | Decoded delivery mode |
| res_trig | output | 1 | Decoded trigger |
| res_level | output | 1 | Decoded level |

## Verification
The bench builds the block with NCPU = 6. This leaves the 3-bit sender index with the out-of-range values 6 and 7. The self and all-but-self shorthands can then be driven with a sender that names no slot. A mask width that is not a power of two also tests lowest-bit isolation and the all-slots broadcast at a width where unused upper bits could leak in. Random slot tables mix the flat, cluster and unknown format values, so one request meets every logical-match rule at the same time.

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver #(
  parameter int NCPU = 8,
  localparam int SW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [1:0]        src_sel,
  input  logic [SW-1:0]     sender,
  input  logic [7:0]        d_dest,
  input  logic              d_logical,
  input  logic [1:0]        d_short,
  input  logic [2:0]        d_dmode,
  input  logic [7:0]        d_vector,
  input  logic              d_trig,
  input  logic              d_level,
  input  logic [31:0]       cmd_lo,
  input  logic [31:0]       cmd_hi,
  input  logic [31:0]       msg_addr,
  input  logic [31:0]       msg_data,
  input  logic [8*NCPU-1:0] cpu_ids,
  input  logic [32*NCPU-1:0] cpu_ldr,
  input  logic [32*NCPU-1:0] cpu_dfr,
  input  logic [NCPU-1:0]   cpu_present,
  output logic              res_valid,
  output logic [NCPU-1:0]   res_mask,
  output logic [7:0]        res_vector,
  output logic [2:0]        res_dmode,
  output logic              res_trig,
  output logic              res_level
);

  localparam logic [2:0] DM_LOWEST = 3'd1;
  localparam logic [3:0] FMT_FLAT  = 4'hF;
  localparam logic [3:0] FMT_CLUS  = 4'h0;

  logic [7:0] f_dest, f_vec;
  logic       f_log, f_trig, f_lvl;
  logic [1:0] f_sh;
  logic [2:0] f_dm;

  always_comb begin
    case (src_sel)
      2'd0: begin
        f_dest = d_dest;   f_log = d_logical; f_sh  = d_short;
        f_dm   = d_dmode;  f_vec = d_vector;  f_trig = d_trig; f_lvl = d_level;
      end
      2'd1: begin
        f_dest = cmd_hi[31:24]; f_log = cmd_lo[11]; f_sh = cmd_lo[19:18];
        f_dm   = cmd_lo[10:8];  f_vec = cmd_lo[7:0];
        f_trig = cmd_lo[15];    f_lvl = cmd_lo[14];
      end
      default: begin
        f_dest = msg_addr[19:12]; f_log = msg_addr[2]; f_sh = 2'd0;
        f_dm   = msg_data[10:8];  f_vec = msg_data[7:0];
        f_trig = msg_data[15];    f_lvl = msg_data[14];
      end
    endcase
  end

  logic [NCPU-1:0] dest_hit, self_hit;

  for (genvar i = 0; i < NCPU; i++) begin : g_slot
    logic [7:0] id, ldr;
    logic [3:0] fmt;
    logic       phys, flat, clus;
    assign id   = cpu_ids[8*i +: 8];
    assign ldr  = cpu_ldr[32*i+24 +: 8];
    assign fmt  = cpu_dfr[32*i+28 +: 4];
    assign phys = (f_dest == 8'hFF) || (id == f_dest);
    assign flat = (fmt == FMT_FLAT) && |(f_dest & ldr);
    assign clus = (fmt == FMT_CLUS) && (f_dest[7:4] == ldr[7:4]) && |(f_dest[3:0] & ldr[3:0]);
    assign dest_hit[i] = f_log ? (flat | clus) : phys;
    assign self_hit[i] = (sender == SW'(i));
  end

  logic [NCPU-1:0] sel, raw, lowest, fin;

  always_comb begin
    case (f_sh)
      2'd0:    sel = dest_hit;
      2'd1:    sel = self_hit;
      2'd2:    sel = '1;
      default: sel = ~self_hit;
    endcase
  end

  assign raw    = sel & cpu_present;
  assign lowest = raw & (~raw + NCPU'(1));
  assign fin    = (f_dm == DM_LOWEST) ? lowest : raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_mask   <= '0;
      res_vector <= '0;
      res_dmode  <= '0;
      res_trig   <= 1'b0;
      res_level  <= 1'b0;
    end else begin
      res_valid <= req;
      if (req) begin
        res_mask   <= fin;
        res_vector <= f_vec;
        res_dmode  <= f_dm;
        res_trig   <= f_trig;
        res_level  <= f_lvl;
      end
    end
  end

  // R2
  strobe_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> res_valid);
  // R2
  strobe_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !res_valid && $stable(res_mask));
  // R7
  absent_excluded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (res_mask & ~$past(cpu_present)) == '0);
  // R8
  lowest_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_dmode == DM_LOWEST |-> $onehot0(res_mask));
  // R6
  shorthand_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && src_sel == 2'd1 && cmd_lo[19:18] == 2'd1 |=> $countones(res_mask) <= 1);

endmodule

// File: tb/sim_irq_dest_resolver.sv
module sim_irq_dest_resolver;
  localparam int N  = 6;
  localparam int SW = 3;

  logic clk = 0, rst_n = 0, req = 0;
  logic [1:0] src_sel = 0;
  logic [SW-1:0] sender = 0;
  logic [7:0] d_dest = 0, d_vector = 0;
  logic d_logical = 0, d_trig = 0, d_level = 0;
  logic [1:0] d_short = 0;
  logic [2:0] d_dmode = 0;
  logic [31:0] cmd_lo = 0, cmd_hi = 0, msg_addr = 0, msg_data = 0;
  logic [8*N-1:0] cpu_ids = 0;
  logic [32*N-1:0] cpu_ldr = 0, cpu_dfr = 0;
  logic [N-1:0] cpu_present = 0;
  logic res_valid, res_trig, res_level;
  logic [N-1:0] res_mask;
  logic [7:0] res_vector;
  logic [2:0] res_dmode;

  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  irq_dest_resolver #(.NCPU(N)) u0 (
    .clk, .rst_n, .req, .src_sel, .sender, .d_dest, .d_logical, .d_short,
    .d_dmode, .d_vector, .d_trig, .d_level, .cmd_lo, .cmd_hi, .msg_addr,
    .msg_data, .cpu_ids, .cpu_ldr, .cpu_dfr, .cpu_present, .res_valid,
    .res_mask, .res_vector, .res_dmode, .res_trig, .res_level);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [N-1:0] model(logic [7:0] dest, logic lg, logic [1:0] sh,
                                         logic [2:0] dm, logic [SW-1:0] snd);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) begin
      logic [7:0] id, ld;
      logic [3:0] ft;
      logic hit;
      id = cpu_ids[8*i +: 8];
      ld = cpu_ldr[32*i+24 +: 8];
      ft = cpu_dfr[32*i+28 +: 4];
      if (!lg) hit = (dest == 8'hFF) || (dest == id);
      else if (ft == 4'hF) hit = (dest & ld) != 0;
      else if (ft == 4'h0) hit = (dest[7:4] == ld[7:4]) && ((dest[3:0] & ld[3:0]) != 0);
      else hit = 0;
      case (sh)
        2'd0: m[i] = hit;
        2'd1: m[i] = (int'(snd) == i);
        2'd2: m[i] = 1'b1;
        default: m[i] = (int'(snd) != i);
      endcase
    end
    m &= cpu_present;
    if (dm == 3'd1) begin
      logic [N-1:0] one;
      one = '0;
      for (int i = N - 1; i >= 0; i--) if (m[i]) one = N'(1) << i;
      m = one;
    end
    return m;
  endfunction

  task automatic run(string tag, logic [1:0] src, logic [7:0] dest, logic lg,
                     logic [1:0] sh, logic [2:0] dm, logic [7:0] vec,
                     logic tr, logic lv, logic [SW-1:0] snd, bit hold_chk);
    logic [N-1:0] exp;
    logic [1:0] esh;
    logic [N-1:0] prev;
    @(negedge clk);
    src_sel = src; sender = snd;
    d_dest = $urandom; d_logical = $urandom; d_short = $urandom; d_dmode = $urandom;
    d_vector = $urandom; d_trig = $urandom; d_level = $urandom;
    cmd_lo = $urandom; cmd_hi = $urandom; msg_addr = $urandom; msg_data = $urandom;
    esh = sh;
    if (src == 0) begin
      d_dest = dest; d_logical = lg; d_short = sh; d_dmode = dm;
      d_vector = vec; d_trig = tr; d_level = lv;
    end else if (src == 1) begin
      cmd_lo[7:0] = vec; cmd_lo[10:8] = dm; cmd_lo[11] = lg; cmd_lo[14] = lv;
      cmd_lo[15] = tr; cmd_lo[19:18] = sh; cmd_hi[31:24] = dest;
    end else begin
      msg_addr[19:12] = dest; msg_addr[2] = lg; msg_data[7:0] = vec;
      msg_data[10:8] = dm; msg_data[14] = lv; msg_data[15] = tr;
      esh = 2'd0;
    end
    exp = model(dest, lg, esh, dm, snd);
    req = 1;
    @(negedge clk);
    req = 0;
    chk({tag, " R2 valid"}, 32'(res_valid), 32'd1);
    chk({tag, " mask"}, 32'(res_mask), 32'(exp));
    chk({tag, " R9/R10/R11 fields"}, {res_vector, res_dmode, res_trig, res_level},
        {vec, dm, tr, lv});
    if (hold_chk) begin
      prev = res_mask;
      cmd_lo = ~cmd_lo; msg_addr = ~msg_addr; d_dest = ~d_dest;
      @(negedge clk);
      chk({tag, " R2 strobe one cycle"}, 32'(res_valid), 32'd0);
      chk({tag, " R2 mask hold"}, 32'(res_mask), 32'(prev));
    end
  endtask

  task automatic fixed_table();
    for (int i = 0; i < N; i++) begin
      cpu_ids[8*i +: 8] = 8'(16 + i);
      cpu_dfr[32*i +: 32] = 32'h0FFF_FFFF;
    end
    cpu_ldr[32*0 +: 32] = 32'h0100_0000; cpu_dfr[32*0+28 +: 4] = 4'hF;
    cpu_ldr[32*1 +: 32] = 32'h0200_0000; cpu_dfr[32*1+28 +: 4] = 4'hF;
    cpu_ldr[32*2 +: 32] = 32'h3100_0000; cpu_dfr[32*2+28 +: 4] = 4'h0;
    cpu_ldr[32*3 +: 32] = 32'h3200_0000; cpu_dfr[32*3+28 +: 4] = 4'h0;
    cpu_ldr[32*4 +: 32] = 32'h4100_0000; cpu_dfr[32*4+28 +: 4] = 4'h0;
    cpu_ldr[32*5 +: 32] = 32'hFF00_0000; cpu_dfr[32*5+28 +: 4] = 4'h5;
    cpu_present = '1;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    fixed_table();
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 32'(res_valid), 0);
    chk("R1 reset mask", 32'(res_mask), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", {31'd0, res_valid}, 0);

    run("R3 broadcast", 0, 8'hFF, 0, 0, 0, 8'h20, 0, 0, 0, 1);
    chk("R3 broadcast all", 32'(res_mask), 32'h3F);
    run("R3 id match", 1, 8'd19, 0, 0, 0, 8'h21, 1, 1, 0, 1);
    chk("R3 id 19 slot3", 32'(res_mask), 32'h08);
    run("R3 no match", 2, 8'd40, 0, 0, 0, 8'h22, 0, 1, 0, 1);
    run("R4 flat", 0, 8'h03, 1, 0, 0, 8'h23, 0, 0, 0, 1);
    chk("R4 flat slots0,1", 32'(res_mask), 32'h03);
    run("R5 cluster", 1, 8'h32, 1, 0, 0, 8'h24, 0, 0, 0, 1);
    chk("R5 cluster slot1,3", 32'(res_mask), 32'h0A);
    run("R5 cluster nibble", 2, 8'h41, 1, 0, 0, 8'h25, 1, 0, 0, 1);
    run("R6 self", 1, 8'h00, 0, 1, 0, 8'h26, 0, 0, 3'd4, 1);
    run("R6 all", 1, 8'h00, 0, 2, 0, 8'h27, 0, 0, 3'd4, 0);
    run("R6 allbut", 1, 8'h00, 0, 3, 0, 8'h28, 0, 0, 3'd4, 0);
    chk("R6 allbut 4", 32'(res_mask), 32'h2F);
    run("R6 self oob", 0, 8'h00, 0, 1, 0, 8'h29, 0, 0, 3'd7, 0);
    run("R6 allbut oob", 0, 8'h00, 0, 3, 0, 8'h2A, 0, 0, 3'd6, 0);
    run("R11 msg ignores shorthand", 2, 8'd17, 0, 3, 0, 8'h2B, 0, 0, 3'd1, 0);
    chk("R11 msg id17", 32'(res_mask), 32'h02);
    cpu_present = 6'b101010;
    run("R7 absent broadcast", 0, 8'hFF, 0, 2, 0, 8'h2C, 0, 0, 0, 1);
    run("R8 lowest", 1, 8'hFF, 0, 0, 3'd1, 8'h2D, 0, 0, 0, 1);
    chk("R8 lowest slot1", 32'(res_mask), 32'h02);
    cpu_present = '1;
    run("R8 lowest cluster", 2, 8'h33, 1, 0, 3'd1, 8'h2E, 0, 0, 0, 1);
    run("R8 lowest empty", 0, 8'd99, 0, 0, 3'd1, 8'h2F, 0, 0, 0, 1);

    for (int k = 0; k < 400; k++) begin
      logic [7:0] dst;
      for (int i = 0; i < N; i++) begin
        logic [3:0] ft;
        cpu_ids[8*i +: 8] = 8'($urandom_range(0, 7));
        cpu_ldr[32*i +: 32] = $urandom;
        case ($urandom_range(0, 2))
          0: ft = 4'hF;
          1: ft = 4'h0;
          default: ft = 4'($urandom);
        endcase
        cpu_dfr[32*i +: 32] = {ft, 28'($urandom)};
      end
      cpu_present = N'($urandom);
      dst = ($urandom_range(0, 7) == 0) ? 8'hFF :
            ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 7)) : 8'($urandom);
      run("R9 random", 2'($urandom), dst, 1'($urandom), 2'($urandom),
          ($urandom_range(0, 2) == 0) ? 3'd1 : 3'($urandom), 8'($urandom),
          1'($urandom), 1'($urandom), SW'($urandom), k % 8 == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule